// File: doc/BRIEF.md
# Fine-Grained Thread Issue Scheduler

This block decides, every clock cycle, which one of four hardware thread contexts may put an instruction into a shared single-issue pipeline. For each thread it keeps a small stall record: a down-counter for a load that hit the first-level cache, a flag for a load that missed, and a flag for an unresolved branch. A thread is eligible when it is active and none of these holds it back. The issue slot then goes round-robin among the eligible threads.

The choice is made combinationally from registered state, so the pipeline can use the select in the same cycle. Switching threads never costs a bubble. The pipeline reports whether the instruction it just issued for the selected thread is a load, and if so whether it hit, or whether it is a branch. The memory system and the branch unit later return per-thread fill-done and branch-resolved pulses. There is no branch prediction: a thread with a branch in flight simply sits out while the others keep issuing.

Top module: `thr_issue_sched`

## Requirements
- R1: A synchronous active-high reset clears every stall record and sets the rotation pointer to thread 0. With all threads active, the first cycle after reset selects thread 0.
- R2: At most one thread is selected per cycle. `issueSel` has at most one bit set, and it is all zero whenever `issueValid` is low.
- R3: The slot rotates among eligible threads. The search starts at the rotation pointer and goes upward with wrap (0,1,2,3,0...), so four active, unstalled threads are granted in the order 0,1,2,3,0.
- R4: There is no switch penalty. `issueValid` is high in every cycle in which at least one thread is eligible, including consecutive cycles that go to different threads.
- R5: A thread granted in cycle N together with `loadIssue`=1 and `cacheHit`=1 has its counter loaded with 3. It is not selected in cycles N+1 to N+3 and is eligible again from N+4.
- R6: A thread granted together with `loadIssue`=1 and `cacheHit`=0 is skipped until a pulse on its `fillDone` bit (bit t for thread t). It is eligible in the cycle after that pulse.
- R7: A thread granted together with `branchIssue`=1 is skipped until a pulse on its `branchResolved` bit (bit t for thread t), while the other threads keep issuing.
- R8: When no thread is eligible, `issueValid` is low and the rotation pointer keeps its value.
- R9: After a grant to thread g, the pointer moves to g+1 modulo 4, so the search in the next cycle begins just after the thread that was last served.
- R10: A thread whose `threadActive` bit is low is never selected. Its stall record is still kept and can still be cleared while it is inactive.
- R11: `loadIssue`, `branchIssue` and `cacheHit` have no effect in a cycle with `issueValid` low. A `fillDone` or `branchResolved` pulse for a thread that is not waiting has no effect.
- R12: `issueId` is the binary index of the selected thread, and `issueSel` has bit `issueId` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| threadActive | input | 4 | Per-thread context active flag |
| loadIssue | input | 1 | The instruction issued this cycle by the selected thread is a load |
| branchIssue | input | 1 | The instruction issued this cycle by the selected thread is a branch |
| cacheHit | input | 1 | Qualifies loadIssue: 1 = first-level hit, 0 = miss |
| fillDone | input | 4 | Per-thread pulse: outstanding miss filled |
| branchResolved | input | 4 | Per-thread pulse: outstanding branch resolved |
| issueValid | output | 1 | A thread is selected this cycle |
| issueSel | output | 4 | One-hot selected thread |
| issueId | output | 2 | Encoded selected thread |

## Verification
A stall record that is stuck or cleared too early shows up at the ports in the very next cycle in which the rotation reaches that thread. A thread either appears too soon after a hit load, miss or branch, or never comes back after its fill or resolve pulse. A wrong pointer update shows up as a grant out of the rotating order within one to four cycles. A wrong idle rule shows up as a grant from a silent or inactive thread, or as a skipped thread after an idle cycle. The hit-latency window is checked with only one thread active, so that the three blank cycles are visible instead of being hidden by the other threads' turns.

// File: rtl/thr_sched_pkg.sv
package thr_sched_pkg;

  // Strobes from the control (arbiter) to the datapath (stall records).
  // The granted thread is carried separately as a one-hot mask.
  typedef struct packed {
    logic grantValid;  // a thread owns the issue slot this cycle
    logic setHit;      // granted thread issued a load that hit
    logic setMiss;     // granted thread issued a load that missed
    logic setBranch;   // granted thread issued a branch
  } stallCtl_t;

endpackage

// File: rtl/thr_stall_slot.sv
module thr_stall_slot
  import thr_sched_pkg::*;
#(
  parameter int HIT_LAT = 3,
  parameter int CNT_W   = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      active,
  input  logic      grantMe,
  input  stallCtl_t ctl,
  input  logic      fillDone,
  input  logic      branchResolved,
  output logic      ready
);

  logic [CNT_W-1:0] hitCnt;
  logic             missWait;
  logic             brWait;

  // Short-load blackout counter
  always_ff @(posedge clk) begin
    if (rst)                        hitCnt <= '0;
    else if (grantMe && ctl.setHit) hitCnt <= CNT_W'(HIT_LAT);
    else if (hitCnt != '0)          hitCnt <= hitCnt - 1'b1;
  end

  // Long-latency miss: a new miss wins over a fill in the same cycle
  always_ff @(posedge clk) begin
    if (rst)                         missWait <= 1'b0;
    else if (grantMe && ctl.setMiss) missWait <= 1'b1;
    else if (fillDone)               missWait <= 1'b0;
  end

  // Unresolved branch
  always_ff @(posedge clk) begin
    if (rst)                           brWait <= 1'b0;
    else if (grantMe && ctl.setBranch) brWait <= 1'b1;
    else if (branchResolved)           brWait <= 1'b0;
  end

  assign ready = active && !missWait && !brWait && (hitCnt == '0);

  a_r5_hit_blocks_next: assert property (@(posedge clk) disable iff (rst)
    (grantMe && ctl.setHit) |=> !ready);

  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    hitCnt <= CNT_W'(HIT_LAT));

  a_r6_miss_blocks_next: assert property (@(posedge clk) disable iff (rst)
    (grantMe && ctl.setMiss) |=> !ready);

  a_r7_branch_blocks_next: assert property (@(posedge clk) disable iff (rst)
    (grantMe && ctl.setBranch) |=> !ready);

  a_r11_no_grant_no_stall: assert property (@(posedge clk) disable iff (rst)
    (!grantMe && ready && active && !fillDone && !branchResolved) |=> (ready || !active));

endmodule

// File: rtl/thr_sched_stall.sv
module thr_sched_stall
  import thr_sched_pkg::*;
#(
  parameter int NUM_THR = 4,
  parameter int HIT_LAT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_THR-1:0] threadActive,
  input  logic [NUM_THR-1:0] grantSel,
  input  stallCtl_t          ctl,
  input  logic [NUM_THR-1:0] fillDone,
  input  logic [NUM_THR-1:0] branchResolved,
  output logic [NUM_THR-1:0] readyMask
);

  localparam int CNT_W = (HIT_LAT < 1) ? 1 : $clog2(HIT_LAT + 1);

  for (genvar t = 0; t < NUM_THR; t++) begin : g_slot
    thr_stall_slot #(
      .HIT_LAT (HIT_LAT),
      .CNT_W   (CNT_W)
    ) u_slot (
      .clk            (clk),
      .rst            (rst),
      .active         (threadActive[t]),
      .grantMe        (grantSel[t]),
      .ctl            (ctl),
      .fillDone       (fillDone[t]),
      .branchResolved (branchResolved[t]),
      .ready          (readyMask[t])
    );
  end

endmodule

// File: rtl/thr_sched_ctrl.sv
module thr_sched_ctrl
  import thr_sched_pkg::*;
#(
  parameter int NUM_THR = 4,
  parameter int ID_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_THR-1:0] readyMask,
  input  logic               loadIssue,
  input  logic               branchIssue,
  input  logic               cacheHit,
  output logic [NUM_THR-1:0] grantSel,
  output logic [ID_W-1:0]    grantId,
  output stallCtl_t          ctl
);

  logic [ID_W-1:0] rrPtr;
  logic            found;
  int              pick;

  // Rotating search starting at the pointer
  always_comb begin
    found = 1'b0;
    pick  = 0;
    for (int k = 0; k < NUM_THR; k++) begin
      int idx;
      idx = (int'(rrPtr) + k) % NUM_THR;
      if (!found && readyMask[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

  always_comb begin
    grantSel = found ? (NUM_THR'(1) << pick) : '0;
    grantId  = ID_W'(pick);
    ctl.grantValid = found;
    ctl.setHit     = found && loadIssue && cacheHit;
    ctl.setMiss    = found && loadIssue && !cacheHit;
    ctl.setBranch  = found && branchIssue;
  end

  // Pointer moves just past the granted thread; holds when idle
  always_ff @(posedge clk) begin
    if (rst) rrPtr <= '0;
    else if (found) begin
      if (pick == NUM_THR - 1) rrPtr <= '0;
      else                     rrPtr <= ID_W'(pick + 1);
    end
  end

  a_r3_grant_is_ready: assert property (@(posedge clk) disable iff (rst)
    ctl.grantValid |-> readyMask[grantId]);

  a_r4_work_conserving: assert property (@(posedge clk) disable iff (rst)
    (readyMask != '0) |-> ctl.grantValid);

  a_r8_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
    (readyMask == '0) |-> (!ctl.grantValid && grantSel == '0));

  a_r8_ptr_holds: assert property (@(posedge clk) disable iff (rst)
    !ctl.grantValid |=> $stable(rrPtr));

endmodule

// File: rtl/thr_issue_sched.sv
module thr_issue_sched
  import thr_sched_pkg::*;
#(
  parameter int NUM_THR = 4,
  parameter int HIT_LAT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_THR-1:0] threadActive,
  input  logic               loadIssue,
  input  logic               branchIssue,
  input  logic               cacheHit,
  input  logic [NUM_THR-1:0] fillDone,
  input  logic [NUM_THR-1:0] branchResolved,
  output logic               issueValid,
  output logic [NUM_THR-1:0] issueSel,
  output logic [(NUM_THR > 1 ? $clog2(NUM_THR) : 1)-1:0] issueId
);

  localparam int ID_W = (NUM_THR > 1) ? $clog2(NUM_THR) : 1;

  logic [NUM_THR-1:0] readyMask;
  logic [NUM_THR-1:0] grantSel;
  logic [ID_W-1:0]    grantId;
  stallCtl_t          ctl;

  thr_sched_ctrl #(
    .NUM_THR (NUM_THR),
    .ID_W    (ID_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .readyMask   (readyMask),
    .loadIssue   (loadIssue),
    .branchIssue (branchIssue),
    .cacheHit    (cacheHit),
    .grantSel    (grantSel),
    .grantId     (grantId),
    .ctl         (ctl)
  );

  thr_sched_stall #(
    .NUM_THR (NUM_THR),
    .HIT_LAT (HIT_LAT)
  ) u_stall (
    .clk            (clk),
    .rst            (rst),
    .threadActive   (threadActive),
    .grantSel       (grantSel),
    .ctl            (ctl),
    .fillDone       (fillDone),
    .branchResolved (branchResolved),
    .readyMask      (readyMask)
  );

  assign issueValid = ctl.grantValid;
  assign issueSel   = grantSel;
  assign issueId    = grantId;

  a_r2_sel_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issueSel));

  a_r2_sel_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
    !issueValid |-> (issueSel == '0));

  a_r12_sel_matches_id: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> issueSel[issueId]);

  a_r10_active_only: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> threadActive[issueId]);

endmodule

// File: tb/tb_thr_issue_sched.sv
module tb_thr_issue_sched;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] threadActive = '0;
  logic       loadIssue = 1'b0;
  logic       branchIssue = 1'b0;
  logic       cacheHit = 1'b0;
  logic [3:0] fillDone = '0;
  logic [3:0] branchResolved = '0;
  logic       issueValid;
  logic [3:0] issueSel;
  logic [1:0] issueId;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  thr_issue_sched dut (
    .clk            (clk),
    .rst            (rst),
    .threadActive   (threadActive),
    .loadIssue      (loadIssue),
    .branchIssue    (branchIssue),
    .cacheHit       (cacheHit),
    .fillDone       (fillDone),
    .branchResolved (branchResolved),
    .issueValid     (issueValid),
    .issueSel       (issueSel),
    .issueId        (issueId)
  );

  // Vector: act[17:14] ld[13] br[12] hit[11] fill[10:7] brr[6:3] expV[2] expId[1:0]
  localparam int NVEC = 40;
  localparam logic [17:0] VEC [NVEC] = '{
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd0}, // 0  R3
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd1}, // 1  R3
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd2}, // 2  R3
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd3}, // 3  R3
    {4'h1,1'b1,1'b0,1'b1,4'h0,4'h0,1'b1,2'd0}, // 4  R5 hit load
    {4'h1,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,2'd0}, // 5  R5
    {4'h1,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,2'd0}, // 6  R5
    {4'h1,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,2'd0}, // 7  R5
    {4'h1,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd0}, // 8  R5 back at N+4
    {4'hF,1'b1,1'b0,1'b0,4'h0,4'h0,1'b1,2'd1}, // 9  R6 miss on t1
    {4'hF,1'b0,1'b1,1'b0,4'h0,4'h0,1'b1,2'd2}, // 10 R7 branch on t2
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd3}, // 11 R3
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd0}, // 12 R3
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd3}, // 13 R7 skip t1,t2
    {4'hF,1'b0,1'b0,1'b0,4'h2,4'h0,1'b1,2'd0}, // 14 R6 fill t1
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd1}, // 15 R6 t1 returns
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h4,1'b1,2'd3}, // 16 R9 resolve t2
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd0}, // 17 R9
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd1}, // 18 R9
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd2}, // 19 R7 t2 returns
    {4'h0,1'b1,1'b1,1'b0,4'h0,4'h0,1'b0,2'd0}, // 20 R8 idle, R11 events ignored
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd3}, // 21 R8 pointer held
    {4'hF,1'b0,1'b0,1'b0,4'hF,4'hF,1'b1,2'd0}, // 22 R11 stray pulses
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd1}, // 23 R11
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd2}, // 24 R11
    {4'hB,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd3}, // 25 R10
    {4'hB,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd0}, // 26 R10
    {4'hB,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd1}, // 27 R10
    {4'hB,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd3}, // 28 R10 t2 inactive
    {4'hF,1'b0,1'b1,1'b0,4'h0,4'h0,1'b1,2'd0}, // 29 R7 branch on t0
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd1}, // 30 R4
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd2}, // 31 R4
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd3}, // 32 R4
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd1}, // 33 R7 t0 held
    {4'hE,1'b0,1'b0,1'b0,4'h0,4'h1,1'b1,2'd2}, // 34 R10 resolve while inactive
    {4'hE,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd3}, // 35 R10
    {4'hE,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd1}, // 36 R10
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd2}, // 37 R3
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd3}, // 38 R3
    {4'hF,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,2'd0}  // 39 R10 t0 cleared while inactive
  };

  localparam int VREQ [NVEC] = '{
    3,3,3,3,5,5,5,5,5,6,7,3,3,7,6,6,9,9,9,7,
    8,8,11,11,11,10,10,10,10,7,4,4,4,7,10,10,10,3,3,10
  };

  task automatic checkOut(input string tag, input int step,
                          input logic expV, input logic [1:0] expId);
    logic [3:0] expSel;
    bit ok;
    expSel = expV ? (4'b0001 << expId) : 4'b0000;
    ok = (issueValid === expV) && (issueSel === expSel) &&
         (!expV || issueId === expId);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s step %0d: valid=%b id=%0d sel=%b, expected valid=%b id=%0d sel=%b",
               tag, step, issueValid, issueId, issueSel, expV, expId, expSel);
    end
  endtask

  task automatic driveIdle();
    threadActive = 4'h0; loadIssue = 1'b0; branchIssue = 1'b0;
    cacheHit = 1'b0; fillDone = '0; branchResolved = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    driveIdle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    // R1: after reset, nothing active -> idle, no select
    checkOut("R1", -1, 1'b0, 2'd0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      threadActive   = VEC[i][17:14];
      loadIssue      = VEC[i][13];
      branchIssue    = VEC[i][12];
      cacheHit       = VEC[i][11];
      fillDone       = VEC[i][10:7];
      branchResolved = VEC[i][6:3];
      #2;
      checkOut($sformatf("R%0d", VREQ[i]), i, VEC[i][2], VEC[i][1:0]);
    end

    // Directed: put stall state in place, then reset mid-run (R1)
    @(negedge clk);
    driveIdle();
    threadActive = 4'hF; loadIssue = 1'b1; cacheHit = 1'b0;
    #2;
    checkOut("R6", 100, 1'b1, 2'd1);  // t1 misses
    @(negedge clk);
    driveIdle();
    threadActive = 4'hF; branchIssue = 1'b1;
    #2;
    checkOut("R7", 101, 1'b1, 2'd2);  // t2 branch
    @(negedge clk);
    driveIdle();
    threadActive = 4'hF;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #2;
      checkOut("R1", 200 + k, 1'b1, 2'(k));  // stalls cleared, pointer at 0
      @(negedge clk);
    end

    // Directed: hit load with all threads active, natural rotation hides gap (R5)
    driveIdle();
    threadActive = 4'hF; loadIssue = 1'b1; cacheHit = 1'b1;
    #2;
    checkOut("R5", 300, 1'b1, 2'd0);
    @(negedge clk);
    driveIdle();
    threadActive = 4'h3;  // only t0,t1: t0 still in blackout
    #2;
    checkOut("R5", 301, 1'b1, 2'd1);
    @(negedge clk);
    #2;
    checkOut("R5", 302, 1'b1, 2'd1);  // t0 counter at 2
    @(negedge clk);
    #2;
    checkOut("R5", 303, 1'b1, 2'd1);  // t0 counter at 1
    @(negedge clk);
    #2;
    checkOut("R5", 304, 1'b1, 2'd0);  // t0 back at N+4

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule